// File: doc/BRIEF.md
# Spanning Tree Port State Table

This block keeps a table of spanning-tree instances. Each instance number (SID) names one entry, and the entry holds a 2-bit forwarding state for every port of the switch. A host reaches the table through a small register window. The window has an operation register, a SID register, a key register and a set of packed port-state data registers. The host prepares the key registers and then starts a command by writing an opcode with the busy flag set. It polls until the busy flag drops.

Two commands act on the table. Load/Purge installs an entry or removes it, and the valid flag in the key register picks which. GetNext walks the table in ascending SID order. Each GetNext returns the next valid instance above the SID register, together with its port states. Iteration continues from whatever the SID register holds, so the host can repeat GetNext without rewriting anything.

Top module: `stp_state_table`

## Requirements
- R1: Writing the operation register (address 0) with bit 15 set while idle starts the command in bits [2:0]: 1 is Load/Purge, 2 is GetNext, and any other code finishes with no effect. From the next cycle, bit 15 of the operation register reads 1 until the command completes. Afterwards the register reads {0, 12'b0, last opcode}. A write with bit 15 clear starts nothing.
- R2: Load/Purge with the valid flag set (bit 12 of the key register, address 2) stores the current data registers as the port states of the SID in the SID register (address 1). The key register reads zero in every bit except bit 12.
- R3: Load/Purge with the valid flag clear removes the entry for that SID, and later GetNext commands skip it.
- R4: GetNext started from SID s, where s is below the top SID, searches s+1 up to the top SID. It returns the lowest valid SID found in the SID register, sets the valid flag, and loads the data registers with that entry's port states.
- R5: When GetNext finds no valid SID in its range, it clears the valid flag, clears all data registers, and leaves the SID register unchanged.
- R6: A repeated GetNext without rewriting the SID register continues after the last SID found. GetNext started from the top SID (all ones) searches every SID from 0 to the top SID.
- R7: Port i occupies bits 2*(i mod 8)+1 : 2*(i mod 8) of the data register at address 3 + i/8. The state codes are 0 disabled, 1 blocking/listening, 2 learning and 3 forwarding. Bits belonging to port numbers at or above NUM_PORTS read 0.
- R8: A value written to the SID register is truncated to log2(NUM_SID) bits.
- R9: Register writes made while busy is set are ignored.
- R10: After reset all registers read 0 and the table holds no valid entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Register read data, combinational from rdAddr |

## Verification
The bench builds the block with NUM_SID=16 and NUM_PORTS=12. Sixteen entries keep every GetNext scan short, so the top SID, the wrap from the top SID back to 0, and an exhausted search all come up often under random traffic. Twelve ports fill only half of the second data register, so the masking of absent port bits is exercised. SID writes above 15 exercise truncation.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int ADDR_W    = 3;
  localparam int ADDR_OP   = 0;
  localparam int ADDR_SID  = 1;
  localparam int ADDR_KEY  = 2;
  localparam int ADDR_DATA = 3;
  localparam int BUSY_BIT  = 15;
  localparam int VALID_BIT = 12;

  localparam logic [2:0] OP_LOAD = 3'd1;
  localparam logic [2:0] OP_NEXT = 3'd2;

  typedef struct packed {
    logic startScan;
    logic execLoad;
    logic hit;
    logic miss;
    logic advance;
  } stpStrobe_t;
endpackage

// File: rtl/stp_ctrl.sv
module stp_ctrl
  import stp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic [2:0] cmdCode,
  input  logic       cursorValid,
  input  logic       cursorTop,
  output stpStrobe_t strobe,
  output logic       busy
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SCAN, S_FINISH} state_t;
  state_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: if (cmdStart) begin
        if (cmdCode == OP_LOAD) stateNext = S_LOAD;
        else if (cmdCode == OP_NEXT) begin
          strobe.startScan = 1'b1;
          stateNext        = S_SCAN;
        end else stateNext = S_FINISH;
      end
      S_LOAD: begin
        strobe.execLoad = 1'b1;
        stateNext       = S_IDLE;
      end
      S_SCAN: begin
        if (cursorValid) begin
          strobe.hit = 1'b1;
          stateNext  = S_IDLE;
        end else if (cursorTop) begin
          strobe.miss = 1'b1;
          stateNext   = S_IDLE;
        end else strobe.advance = 1'b1;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/stp_datapath.sv
module stp_datapath
  import stp_pkg::*;
#(
  parameter int NUM_SID   = 64,
  parameter int NUM_PORTS = 16,
  localparam int IW = $clog2(NUM_SID),
  localparam int SW = 2 * NUM_PORTS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [15:0]       rdData,
  input  logic              busy,
  input  stpStrobe_t        strobe,
  output logic              cmdStart,
  output logic [2:0]        cmdCode,
  output logic              cursorValid,
  output logic              cursorTop,
  output logic [IW-1:0]     sidReg,
  output logic              keyValid,
  output logic [SW-1:0]     dataFlat
);
  localparam int NDATA = (NUM_PORTS + 7) / 8;
  localparam int DW    = NDATA * 16;
  localparam logic [IW-1:0] TOP = IW'(NUM_SID - 1);

  logic [2:0]    lastOp;
  logic [IW-1:0] cursor;
  logic [NUM_SID-1:0] tblValid;
  logic [SW-1:0] tblState [NUM_SID];
  logic [DW-1:0] dataWide, merged;
  logic          hostWr;

  assign hostWr   = wrEn && !busy;
  assign cmdStart = hostWr && (wrAddr == ADDR_W'(ADDR_OP)) && wrData[BUSY_BIT];
  assign cmdCode  = wrData[2:0];
  assign dataWide = DW'(dataFlat);

  assign cursorValid = tblValid[cursor];
  assign cursorTop   = (cursor == TOP);

  always_comb begin
    merged = dataWide;
    for (int k = 0; k < NDATA; k++)
      if (hostWr && wrAddr == ADDR_W'(ADDR_DATA + k))
        merged[k*16 +: 16] = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sidReg   <= '0;
      keyValid <= 1'b0;
      dataFlat <= '0;
      lastOp   <= '0;
      cursor   <= '0;
      tblValid <= '0;
    end else begin
      if (hostWr) begin
        if (wrAddr == ADDR_W'(ADDR_OP))  lastOp   <= wrData[2:0];
        if (wrAddr == ADDR_W'(ADDR_SID)) sidReg   <= wrData[IW-1:0];
        if (wrAddr == ADDR_W'(ADDR_KEY)) keyValid <= wrData[VALID_BIT];
        dataFlat <= merged[SW-1:0];
      end
      if (strobe.startScan) cursor <= (sidReg == TOP) ? '0 : sidReg + 1'b1;
      if (strobe.advance)   cursor <= cursor + 1'b1;
      if (strobe.hit) begin
        sidReg   <= cursor;
        keyValid <= 1'b1;
        dataFlat <= tblState[cursor];
      end
      if (strobe.miss) begin
        keyValid <= 1'b0;
        dataFlat <= '0;
      end
      if (strobe.execLoad) tblValid[sidReg] <= keyValid;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.execLoad) tblState[sidReg] <= keyValid ? dataFlat : '0;
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(ADDR_OP))  rdData = {busy, 12'b0, lastOp};
    if (rdAddr == ADDR_W'(ADDR_SID)) rdData = 16'(sidReg);
    if (rdAddr == ADDR_W'(ADDR_KEY)) rdData[VALID_BIT] = keyValid;
    for (int k = 0; k < NDATA; k++)
      if (rdAddr == ADDR_W'(ADDR_DATA + k)) rdData = dataWide[k*16 +: 16];
  end
endmodule

// File: rtl/stp_state_table.sv
module stp_state_table
  import stp_pkg::*;
#(
  parameter int NUM_SID   = 64,
  parameter int NUM_PORTS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic [2:0]  rdAddr,
  output logic [15:0] rdData
);
  localparam int IW = $clog2(NUM_SID);
  localparam int SW = 2 * NUM_PORTS;

  stpStrobe_t    strobe;
  logic          busy, cmdStart, cursorValid, cursorTop, keyValid;
  logic [2:0]    cmdCode;
  logic [IW-1:0] sidReg;
  logic [SW-1:0] dataFlat;

  stp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdCode(cmdCode),
    .cursorValid(cursorValid), .cursorTop(cursorTop),
    .strobe(strobe), .busy(busy)
  );

  stp_datapath #(.NUM_SID(NUM_SID), .NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .strobe(strobe),
    .cmdStart(cmdStart), .cmdCode(cmdCode), .cursorValid(cursorValid),
    .cursorTop(cursorTop), .sidReg(sidReg), .keyValid(keyValid),
    .dataFlat(dataFlat)
  );
endmodule

// File: rtl/stp_checker.sv
module stp_checker
  import stp_pkg::*;
#(
  parameter int IW = 6,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [2:0]    wrAddr,
  input logic          busy,
  input logic          cmdStart,
  input stpStrobe_t    strobe,
  input logic          keyValid,
  input logic [IW-1:0] sidReg,
  input logic [SW-1:0] dataFlat
);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> busy);
  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
  // R4
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hit |=> keyValid);
  // R5
  miss_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.miss |=> (!keyValid && dataFlat == '0));
  // R9
  busy_sid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && wrAddr == 3'(ADDR_SID) && !strobe.hit) |=> $stable(sidReg));
endmodule

bind stp_state_table stp_checker #(.IW(IW), .SW(SW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .busy(busy),
  .cmdStart(cmdStart), .strobe(strobe), .keyValid(keyValid),
  .sidReg(sidReg), .dataFlat(dataFlat)
);

// File: tb/sim_stp_state_table.sv
`timescale 1ns/1ps
module sim_stp_state_table;
  localparam int NSID  = 16;
  localparam int NPORT = 12;
  localparam int TOP   = NSID - 1;
  localparam logic [31:0] DMASK = 32'h00FF_FFFF;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [2:0] wrAddr = 0, rdAddr = 0;
  logic [15:0] wrData = 0, rdData;
  int compared = 0, mismatched = 0;
  bit done = 0;

  logic        expValid [NSID];
  logic [31:0] expState [NSID];
  int bSid = 0;

  always #2 clk = ~clk;

  stp_state_table #(.NUM_SID(NSID), .NUM_PORTS(NPORT)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rdAddr = a; #1; v = rdData;
  endtask

  task automatic waitIdle();
    logic [15:0] v;
    for (int n = 0; n < 100; n++) begin
      rd(3'd0, v);
      if (!v[15]) return;
      @(negedge clk);
    end
    check("R1 busy never cleared", 1, 0);
  endtask

  function automatic int nextSid(input int s);
    int lo = (s == TOP) ? 0 : s + 1;
    for (int i = lo; i <= TOP; i++) if (expValid[i]) return i;
    return -1;
  endfunction

  task automatic load(input logic [15:0] sid, input bit valid, input logic [31:0] d);
    wr(3'd1, sid);
    wr(3'd2, valid ? 16'h1000 : 16'h0);
    wr(3'd3, d[15:0]);
    wr(3'd4, d[31:16]);
    wr(3'd0, 16'h8001);
    waitIdle();
    bSid = int'(sid) % NSID;
    expValid[bSid] = valid;
    expState[bSid] = valid ? (d & DMASK) : 32'h0;
  endtask

  task automatic getNext(input string tag);
    logic [15:0] v0, v1, s, k;
    int n;
    n = nextSid(bSid);
    wr(3'd0, 16'h8002);
    waitIdle();
    rd(3'd1, s); rd(3'd2, k); rd(3'd3, v0); rd(3'd4, v1);
    if (n >= 0) bSid = n;
    check({tag, " sid"}, 32'(s), 32'(bSid));
    check({tag, " valid"}, 32'(k), (n >= 0) ? 32'h1000 : 32'h0);
    check({tag, " data"}, {v1, v0}, (n >= 0) ? expState[n] : 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < NSID; i++) begin expValid[i] = 0; expState[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R10 reset reg", 32'(v), 0);
    end
    // R5 empty table from top SID
    wr(3'd1, 16'(TOP)); bSid = TOP;
    getNext("R5 empty");
    // R1 opcode without busy flag
    wr(3'd0, 16'h0002);
    rd(3'd0, v); check("R1 no start", 32'(v), 32'h0002);
    // R1 unknown opcode
    wr(3'd0, 16'h8005);
    rd(3'd0, v); check("R1 unknown busy", 32'(v), 32'h8005);
    @(negedge clk);
    rd(3'd0, v); check("R1 unknown done", 32'(v), 32'h0005);
    // R7 absent port bits masked
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v); check("R7 mask", 32'(v), 32'h00FF);
    // R2 R1 load, busy visible next cycle
    wr(3'd1, 16'd3); wr(3'd2, 16'h1000); wr(3'd3, 16'hE4C1); wr(3'd4, 16'h0027);
    wr(3'd0, 16'h8001);
    rd(3'd0, v); check("R1 busy", 32'(v), 32'h8001);
    waitIdle();
    rd(3'd0, v); check("R1 done", 32'(v), 32'h0001);
    rd(3'd2, v); check("R2 key", 32'(v), 32'h1000);
    expValid[3] = 1; expState[3] = 32'h0027_E4C1; bSid = 3;
    load(16'd9, 1, 32'h5555_AAAA);
    // R4 R6 iteration
    wr(3'd1, 16'(TOP)); bSid = TOP;
    getNext("R4 first");
    getNext("R6 continue");
    getNext("R5 exhausted");
    load(16'd15, 1, 32'h0012_3456);
    bSid = 9; wr(3'd1, 16'd9);
    getNext("R4 top");
    getNext("R6 wrap");
    // R3 purge
    load(16'd9, 0, 32'hFFFF_FFFF);
    wr(3'd1, 16'd3); bSid = 3;
    getNext("R3 purged skip");
    // R8 truncation
    wr(3'd1, 16'h0035);
    rd(3'd1, v); check("R8 truncate", 32'(v), 32'h5);
    // R9 write during busy ignored
    wr(3'd1, 16'd6); wr(3'd2, 16'h1000);
    wr(3'd0, 16'h8001);
    wr(3'd1, 16'd11);
    waitIdle();
    rd(3'd1, v); check("R9 sid held", 32'(v), 32'd6);
    expValid[6] = 1; expState[6] = {16'h0, 16'h0} | (32'hFFFF_FFFF & 32'h0);
    begin
      logic [15:0] a, b;
      rd(3'd3, a); rd(3'd4, b);
      expState[6] = {b, a};
    end
    bSid = 6;
    getNext("R9 after");
    // random mix
    for (int it = 0; it < 120; it++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 5) begin
        logic [15:0] s = 16'($urandom_range(0, 63));
        load(s, ($urandom_range(0, 9) < 7), $urandom());
      end else if (r < 7) begin
        int s = int'($urandom_range(0, TOP));
        wr(3'd1, 16'(s)); bSid = s;
        getNext("R4 random");
      end else getNext("R6 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule